// File: doc/BRIEF.md
# Burst Address Sequencer

This block produces the word address for a four-beat burst on a synchronous SRAM. On any clock edge where either of two active-low address strobes is asserted, it captures the external address and restarts the burst at beat zero. On later edges with no strobe, an active-low advance input steps the burst to the next beat. With advance high, the edge is a wait cycle: the current beat and address stay as they are.

The two low-order address bits come from the start value and the beat index, through one of two orderings. The linear ordering adds the beat index to the start value, modulo the group size. The interleaved ordering XORs the beat index with the start value. A static order-select pin chooses between them. The upper address bits keep their captured value for the whole burst. After the last beat, further advances wrap around inside the same aligned group.

All pins are plain control and address pins sampled on the rising edge. No data stream passes through this block, so it has no valid/ready handshake and no back-pressure.

Top module: `burst_addr_seq`

## Requirements
- R1: A synchronous active-high reset `rst` forces `beat_out` to 0 and `addr_out` to 0 after the edge on which it is sampled high.
- R2: `strobe_proc_n` low at a rising edge loads `addr_in`. After that edge, `addr_out` equals the loaded address and `beat_out` is 0.
- R3: `strobe_ctrl_n` low at a rising edge has the same effect as R2, whether used alone or together with `strobe_proc_n`.
- R4: When both strobes are high and `adv_n` is low at an edge, `beat_out` increments by one modulo 4.
- R5: When both strobes and `adv_n` are high at an edge (a wait cycle), `addr_out` and `beat_out` keep their values.
- R6: With `order_il` = 0 (linear), `addr_out[1:0]` = (S + `beat_out`) mod 4, where S is the loaded `addr_in[1:0]`.
- R7: With `order_il` = 1 (interleaved), `addr_out[1:0]` = S XOR `beat_out`.
- R8: `addr_out[ADDR_W-1:2]` changes only on a load or a reset. Advancing past beat 3 wraps to beat 0 in the same group and never carries into the upper bits.
- R9: If a strobe and `adv_n` are both low at the same edge, the load wins: `addr_out` equals `addr_in` unchanged and `beat_out` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| addr_in | input | ADDR_W | External word address |
| strobe_proc_n | input | 1 | Processor-side address strobe, active low |
| strobe_ctrl_n | input | 1 | Controller-side address strobe, active low |
| adv_n | input | 1 | Advance request, active low; high means wait |
| order_il | input | 1 | Static ordering select: 0 linear, 1 interleaved |
| addr_out | output | ADDR_W | Current burst word address |
| beat_out | output | CNT_W | Current beat index |

## Verification
The bench sweeps every start pair under both orderings, with varied upper bits. It inserts wait cycles between beats and advances past the fourth beat. A sequencer that applied the wrong ordering, or swapped the two orderings, would give a wrong low pair on some beat. A sequencer that let the beat carry would change the upper bits at the wrap. A sequencer that advanced on a wait cycle would skip a beat. The bench also asserts a strobe together with advance and resets in the middle of a burst. A design that gave advance priority over the load would return the loaded address already stepped by one. A design that ignored reset would keep a stale beat.

// File: rtl/bsq_pkg.sv
package bsq_pkg;
  typedef enum logic [1:0] {
    OP_HOLD = 2'd0,
    OP_STEP = 2'd1,
    OP_LOAD = 2'd2
  } bsq_op_e;
endpackage

// File: rtl/bsq_ctrl_decode.sv
module bsq_ctrl_decode
  import bsq_pkg::*;
(
  input  logic    strobe_proc_n,
  input  logic    strobe_ctrl_n,
  input  logic    adv_n,
  output bsq_op_e op
);
  // Either strobe outranks an advance request on the same edge.
  always_comb begin
    if (!strobe_proc_n || !strobe_ctrl_n) op = OP_LOAD;
    else if (!adv_n)                      op = OP_STEP;
    else                                  op = OP_HOLD;
  end
endmodule

// File: rtl/bsq_base_reg.sv
module bsq_base_reg
  import bsq_pkg::*;
#(
  parameter int ADDR_W = 17
) (
  input  logic              clk,
  input  logic              rst,
  input  bsq_op_e           op,
  input  logic [ADDR_W-1:0] addr_in,
  output logic [ADDR_W-1:0] base_q
);
  always_ff @(posedge clk) begin
    if (rst)                 base_q <= '0;
    else if (op == OP_LOAD)  base_q <= addr_in;
  end
endmodule

// File: rtl/bsq_beat_ctr.sv
module bsq_beat_ctr
  import bsq_pkg::*;
#(
  parameter int CNT_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  bsq_op_e          op,
  output logic [CNT_W-1:0] beat_q
);
  always_ff @(posedge clk) begin
    if (rst) beat_q <= '0;
    else begin
      unique case (op)
        OP_LOAD: beat_q <= '0;
        OP_STEP: beat_q <= beat_q + 1'b1;  // natural wrap inside the group
        default: beat_q <= beat_q;
      endcase
    end
  end
endmodule

// File: rtl/bsq_order_map.sv
module bsq_order_map #(
  parameter int CNT_W = 2
) (
  input  logic [CNT_W-1:0] start,
  input  logic [CNT_W-1:0] beat,
  input  logic             order_il,
  output logic [CNT_W-1:0] low
);
  logic [CNT_W-1:0] lin_low;
  logic [CNT_W-1:0] il_low;

  assign lin_low = start + beat;
  genvar i;
  generate
    for (i = 0; i < CNT_W; i++) begin : g_il
      assign il_low[i] = start[i] ^ beat[i];
    end
  endgenerate

  assign low = order_il ? il_low : lin_low;
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
  import bsq_pkg::*;
#(
  parameter int ADDR_W = 17,
  parameter int CNT_W  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              strobe_proc_n,
  input  logic              strobe_ctrl_n,
  input  logic              adv_n,
  input  logic              order_il,
  output logic [ADDR_W-1:0] addr_out,
  output logic [CNT_W-1:0]  beat_out
);
  localparam int UP_W = ADDR_W - CNT_W;

  bsq_op_e           op;
  logic [ADDR_W-1:0] base_q;
  logic [CNT_W-1:0]  beat_q;
  logic [CNT_W-1:0]  low;

  bsq_ctrl_decode u_dec (
    .strobe_proc_n (strobe_proc_n),
    .strobe_ctrl_n (strobe_ctrl_n),
    .adv_n         (adv_n),
    .op            (op)
  );

  bsq_base_reg #(.ADDR_W(ADDR_W)) u_base (
    .clk     (clk),
    .rst     (rst),
    .op      (op),
    .addr_in (addr_in),
    .base_q  (base_q)
  );

  bsq_beat_ctr #(.CNT_W(CNT_W)) u_ctr (
    .clk    (clk),
    .rst    (rst),
    .op     (op),
    .beat_q (beat_q)
  );

  bsq_order_map #(.CNT_W(CNT_W)) u_map (
    .start    (base_q[CNT_W-1:0]),
    .beat     (beat_q),
    .order_il (order_il),
    .low      (low)
  );

  assign addr_out = {base_q[ADDR_W-1:CNT_W], low};
  assign beat_out = beat_q;

  logic [UP_W-1:0] unused_up;
  assign unused_up = base_q[ADDR_W-1:CNT_W];
endmodule

// File: rtl/bsq_checker.sv
module bsq_checker #(
  parameter int ADDR_W = 17,
  parameter int CNT_W  = 2
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] addr_in,
  input logic              strobe_proc_n,
  input logic              strobe_ctrl_n,
  input logic              adv_n,
  input logic              order_il,
  input logic [ADDR_W-1:0] addr_out,
  input logic [CNT_W-1:0]  beat_out
);
  logic rst_seen = 1'b0;
  logic any_ld;
  assign any_ld = !strobe_proc_n || !strobe_ctrl_n;

  always_ff @(posedge clk) rst_seen <= rst;

  // R1: outputs are zero on the cycle after a sampled reset
  always @(negedge clk) begin
    if (rst_seen) begin
      p_reset_zero_r1: assert (beat_out == '0 && addr_out == '0);
    end
  end

  // R2, R3, R9: load captures the external address unchanged
  p_load_exact_r9: assert property (@(posedge clk) disable iff (rst)
    any_ld |=> (addr_out == $past(addr_in) && beat_out == '0));

  // R4: a step adds one to the beat
  p_step_r4: assert property (@(posedge clk) disable iff (rst)
    (!any_ld && !adv_n) |=> beat_out == CNT_W'($past(beat_out) + 1'b1));

  // R5: a wait cycle keeps everything
  p_wait_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (!any_ld && adv_n) ##1 $stable(order_il) |->
      ($stable(addr_out) && $stable(beat_out)));

  // R8: upper bits move only on a load
  p_upper_fixed_r8: assert property (@(posedge clk) disable iff (rst)
    !any_ld |=> $stable(addr_out[ADDR_W-1:CNT_W]));
endmodule

bind burst_addr_seq bsq_checker #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .addr_in       (addr_in),
  .strobe_proc_n (strobe_proc_n),
  .strobe_ctrl_n (strobe_ctrl_n),
  .adv_n         (adv_n),
  .order_il      (order_il),
  .addr_out      (addr_out),
  .beat_out      (beat_out)
);

// File: tb/tb_burst_addr_seq.sv
module tb_burst_addr_seq;
  localparam int AW = 17;
  localparam int CW = 2;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] addr_in = '0;
  logic          strobe_proc_n = 1'b1;
  logic          strobe_ctrl_n = 1'b1;
  logic          adv_n = 1'b1;
  logic          order_il = 1'b0;
  logic [AW-1:0] addr_out;
  logic [CW-1:0] beat_out;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;  // 200 MHz

  burst_addr_seq #(.ADDR_W(AW), .CNT_W(CW)) dut (
    .clk(clk), .rst(rst), .addr_in(addr_in),
    .strobe_proc_n(strobe_proc_n), .strobe_ctrl_n(strobe_ctrl_n),
    .adv_n(adv_n), .order_il(order_il),
    .addr_out(addr_out), .beat_out(beat_out)
  );

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic chk(string req, logic [AW-1:0] exp_a, int exp_b);
    n_run++;
    if (addr_out !== exp_a || beat_out !== CW'(exp_b)) begin
      n_fail++;
      $display("FAIL %s: addr=%h beat=%0d expected addr=%h beat=%0d",
               req, addr_out, beat_out, exp_a, exp_b);
    end
  endtask

  function automatic logic [AW-1:0] expect_addr(logic [AW-1:0] a, int k, bit il);
    int s = int'(a[1:0]);
    int lo = il ? (s ^ (k % 4)) : ((s + k) % 4);
    return {a[AW-1:2], 2'(lo)};
  endfunction

  task automatic load(logic [AW-1:0] a, bit use_ctrl, bit also_adv);
    addr_in = a;
    if (use_ctrl) strobe_ctrl_n = 1'b0; else strobe_proc_n = 1'b0;
    adv_n = also_adv ? 1'b0 : 1'b1;
    cyc();
    strobe_proc_n = 1'b1; strobe_ctrl_n = 1'b1; adv_n = 1'b1;
    addr_in = ~a;  // garbage on the bus afterwards
  endtask

  initial begin
    cyc(); cyc();
    rst = 1'b0;
    cyc();
    chk("R1 reset", '0, 0);

    for (int m = 0; m < 2; m++) begin
      order_il = m[0];
      for (int s = 0; s < 4; s++) begin
        logic [AW-1:0] a;
        a = AW'((s * 32'h1357) ^ (m * 32'h0A5A4)) & ~AW'(3) | AW'(s);
        load(a, s[0], 1'b0);
        chk(s[0] ? "R3 ctrl load" : "R2 proc load", a, 0);
        for (int k = 1; k <= 6; k++) begin
          adv_n = 1'b0; cyc(); adv_n = 1'b1;
          chk(m ? "R7 interleaved / R4 step / R8 wrap"
                : "R6 linear / R4 step / R8 wrap",
              expect_addr(a, k, m[0]), k % 4);
          if (k == 2) begin
            cyc(); cyc();
            chk("R5 wait hold", expect_addr(a, k, m[0]), k % 4);
          end
        end
      end
    end

    // R9: load and advance together
    order_il = 1'b0;
    load(17'h1ABCD, 1'b0, 1'b0);
    adv_n = 1'b0; cyc(); adv_n = 1'b1;
    load(17'h0F0F2, 1'b0, 1'b1);
    chk("R9 load priority", 17'h0F0F2, 0);
    load(17'h13331, 1'b1, 1'b1);
    chk("R9 load priority ctrl", 17'h13331, 0);
    strobe_proc_n = 1'b0; strobe_ctrl_n = 1'b0; addr_in = 17'h00007; cyc();
    strobe_proc_n = 1'b1; strobe_ctrl_n = 1'b1;
    chk("R3 both strobes", 17'h00007, 0);

    // R1: reset mid-burst
    adv_n = 1'b0; cyc(); adv_n = 1'b1;
    rst = 1'b1; cyc(); rst = 1'b0;
    chk("R1 reset mid-burst", '0, 0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: run hung");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule